// File: doc/BRIEF.md
# VLAN Membership Table Command Engine

This block keeps a small table that maps 12-bit VLAN identifiers to port membership masks. Software programs it through two 32-bit registers on a simple register bus. The data register holds a member mask. The command register holds an opcode, a VID, a port number and a self-clearing busy bit. Writing the command register with the busy bit set starts an operation. There are five operations: no-op, flush every entry, load an entry, purge an entry, and strip one port from every entry. The engine clears busy when the operation is done. A load that finds neither a matching VID nor a free slot raises a full flag instead of changing the table.

Other logic queries the table through a lookup stream. A request carries a VID with a valid strobe, and the response appears one cycle later as a membership mask and a hit flag. The block accepts a lookup on every cycle, so `lk_ready` is held high and the requester never sees back-pressure. The response side has no ready signal, and the consumer must take each response in the cycle it is valid. A lookup made while a command is running sees the table as it stood before that cycle's update.

Top module: `vtu_cmd_engine`

## Requirements
- R1: After reset, both registers read as zero, every entry is invalid, and every lookup misses.
- R2: A command-register write with bit 3 (busy) set starts the command in bits [2:0]. Busy reads 1 until the command completes. No-op (0), load (2), purge (3) and the unused codes 5 to 7 each complete in one cycle.
- R3: A load (opcode 2) of a VID (command bits [27:16]) that is not in the table stores it in a free entry, with the mask from data bits [9:0]. A later lookup of that VID hits and returns that mask.
- R4: A load of a VID that is already present replaces that entry's mask and uses no further entry.
- R5: A load that finds no matching VID and no free entry leaves the table unchanged and sets command bit 4 (full). Any later accepted command-register write clears bit 4.
- R6: A purge (opcode 3) invalidates the entry whose VID matches. A purge of an absent VID changes nothing.
- R7: A flush (opcode 1) invalidates every entry and keeps busy high for exactly ENTRIES cycles (16).
- R8: A remove-port (opcode 4) clears bit P of every valid entry's mask, where P is command bits [11:8], and keeps busy high for 16 cycles. When P is 10 or more, no mask changes.
- R9: Writes to the command register while busy reads 1 are ignored. The opcode, VID and port fields keep their values and the write starts no operation.
- R10: A lookup with `lk_valid` high gives `lk_rsp_valid` high one cycle later, with `lk_hit` and `lk_mask`. A miss returns a zero mask. `lk_rsp_valid` is low in any cycle that follows a cycle with no request.
- R11: The data register reads back the mask in bits [9:0] and the valid flag in bit 11. All its other bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_sel | input | 1 | Register select: 0 is the command register, 1 is the data register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the selected register (combinational) |
| lk_valid | input | 1 | Lookup request valid |
| lk_ready | output | 1 | Lookup request accepted (always 1) |
| lk_vid | input | 12 | VID to look up |
| lk_rsp_valid | output | 1 | Lookup response valid |
| lk_hit | output | 1 | The looked-up VID is in the table |
| lk_mask | output | 10 | Membership mask of the hit entry, zero on a miss |

## Verification
Register reads are combinational, so the bench reads a register in the same falling-edge window in which it samples everything else. Busy rises on the clock edge that takes the command write. It then stays high for 1 cycle for a single-entry command and for 16 cycles for a table walk. The bench counts the falling edges on which busy reads 1 and compares that count with the expected cycle count. A lookup is driven at one falling edge and its response is sampled at the next one, which lies exactly one rising edge later. Table contents are checked only after busy has cleared, so a walk that is still running never gives a partial result.

// File: rtl/vtu_pkg.sv
package vtu_pkg;
  parameter int VID_W  = 12;
  parameter int MASK_W = 10;
  parameter int PORT_W = 4;
  parameter int OP_W   = 3;

  localparam logic [OP_W-1:0] OP_NOP    = 3'd0;
  localparam logic [OP_W-1:0] OP_FLUSH  = 3'd1;
  localparam logic [OP_W-1:0] OP_LOAD   = 3'd2;
  localparam logic [OP_W-1:0] OP_PURGE  = 3'd3;
  localparam logic [OP_W-1:0] OP_RMPORT = 3'd4;

  // command register field positions
  localparam int CMD_BUSY_BIT = 3;
  localparam int CMD_FULL_BIT = 4;
  localparam int CMD_PORT_LSB = 8;
  localparam int CMD_VID_LSB  = 16;
  // data register field positions
  localparam int DAT_VALID_BIT = 11;

  typedef struct packed {
    logic              valid;
    logic [VID_W-1:0]  vid;
    logic [MASK_W-1:0] mask;
  } vtu_entry_t;

  function automatic logic is_walk(input logic [OP_W-1:0] op);
    return (op == OP_FLUSH) || (op == OP_RMPORT);
  endfunction
endpackage

// File: rtl/vtu_cmd_regs.sv
module vtu_cmd_regs
  import vtu_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_sel,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              done,
  input  logic              set_full,
  output logic [OP_W-1:0]   op_q,
  output logic [VID_W-1:0]  vid_q,
  output logic [PORT_W-1:0] port_q,
  output logic              busy_q,
  output logic              full_q,
  output logic [MASK_W-1:0] dmask_q,
  output logic              dvalid_q
);
  logic cmd_take;
  logic dat_take;

  assign cmd_take = bus_wr && !bus_sel && !busy_q;
  assign dat_take = bus_wr && bus_sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q   <= '0;
      vid_q  <= '0;
      port_q <= '0;
      busy_q <= 1'b0;
      full_q <= 1'b0;
    end else if (cmd_take) begin
      op_q   <= bus_wdata[OP_W-1:0];
      busy_q <= bus_wdata[CMD_BUSY_BIT];
      port_q <= bus_wdata[CMD_PORT_LSB +: PORT_W];
      vid_q  <= bus_wdata[CMD_VID_LSB +: VID_W];
      full_q <= 1'b0;
    end else begin
      if (done)     busy_q <= 1'b0;
      if (set_full) full_q <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dmask_q  <= '0;
      dvalid_q <= 1'b0;
    end else if (dat_take) begin
      dmask_q  <= bus_wdata[MASK_W-1:0];
      dvalid_q <= bus_wdata[DAT_VALID_BIT];
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_sel) begin
      bus_rdata[MASK_W-1:0]    = dmask_q;
      bus_rdata[DAT_VALID_BIT] = dvalid_q;
    end else begin
      bus_rdata[OP_W-1:0]               = op_q;
      bus_rdata[CMD_BUSY_BIT]           = busy_q;
      bus_rdata[CMD_FULL_BIT]           = full_q;
      bus_rdata[CMD_PORT_LSB +: PORT_W] = port_q;
      bus_rdata[CMD_VID_LSB +: VID_W]   = vid_q;
    end
  end

  logic unused_wbits;
  assign unused_wbits = ^{bus_wdata[31:28], bus_wdata[15:12], bus_wdata[10],
                          bus_wdata[7:4]};
endmodule

// File: rtl/vtu_table.sv
module vtu_table
  import vtu_pkg::*;
#(
  parameter int ENTRIES = 16,
  localparam int IDX_W = $clog2(ENTRIES)
)(
  input  logic              clk,
  input  logic              rst_n,
  // single write port
  input  logic              upd_en,
  input  logic [IDX_W-1:0]  upd_idx,
  input  vtu_entry_t        upd_ent,
  // search on the command VID
  input  logic [VID_W-1:0]  srch_vid,
  output logic              srch_hit,
  output logic [IDX_W-1:0]  srch_idx,
  output logic              free_any,
  output logic [IDX_W-1:0]  free_idx,
  // indexed read for table walks
  input  logic [IDX_W-1:0]  rd_idx,
  output vtu_entry_t        rd_ent,
  // lookup stream
  input  logic              lk_valid,
  input  logic [VID_W-1:0]  lk_vid,
  output logic              lk_rsp_valid,
  output logic              lk_hit,
  output logic [MASK_W-1:0] lk_mask
);
  vtu_entry_t ent [ENTRIES];

  for (genvar gi = 0; gi < ENTRIES; gi++) begin : gen_entry
    vtu_entry_t ent_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        ent_q <= '0;
      else if (upd_en && (upd_idx == IDX_W'(gi)))
        ent_q <= upd_ent;
    end
    assign ent[gi] = ent_q;
  end

  logic              lk_hit_c;
  logic [MASK_W-1:0] lk_mask_c;

  // descending scan so the lowest index wins
  always_comb begin
    srch_hit  = 1'b0;
    srch_idx  = '0;
    free_any  = 1'b0;
    free_idx  = '0;
    lk_hit_c  = 1'b0;
    lk_mask_c = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (ent[i].valid && (ent[i].vid == srch_vid)) begin
        srch_hit = 1'b1;
        srch_idx = IDX_W'(i);
      end
      if (!ent[i].valid) begin
        free_any = 1'b1;
        free_idx = IDX_W'(i);
      end
      if (ent[i].valid && (ent[i].vid == lk_vid)) begin
        lk_hit_c  = 1'b1;
        lk_mask_c = ent[i].mask;
      end
    end
  end

  assign rd_ent = ent[rd_idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lk_rsp_valid <= 1'b0;
      lk_hit       <= 1'b0;
      lk_mask      <= '0;
    end else begin
      lk_rsp_valid <= lk_valid;
      lk_hit       <= lk_valid && lk_hit_c;
      lk_mask      <= (lk_valid && lk_hit_c) ? lk_mask_c : '0;
    end
  end
endmodule

// File: rtl/vtu_engine.sv
module vtu_engine
  import vtu_pkg::*;
#(
  parameter int ENTRIES = 16,
  localparam int IDX_W = $clog2(ENTRIES)
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              busy,
  input  logic [OP_W-1:0]   op,
  input  logic [VID_W-1:0]  vid,
  input  logic [PORT_W-1:0] port,
  input  logic [MASK_W-1:0] dmask,
  input  logic              srch_hit,
  input  logic [IDX_W-1:0]  srch_idx,
  input  logic              free_any,
  input  logic [IDX_W-1:0]  free_idx,
  input  vtu_entry_t        rd_ent,
  output logic [IDX_W-1:0]  rd_idx,
  output logic              upd_en,
  output logic [IDX_W-1:0]  upd_idx,
  output vtu_entry_t        upd_ent,
  output logic              done,
  output logic              set_full
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(ENTRIES - 1);

  logic [IDX_W-1:0] walk_q;
  logic             walking;

  assign walking = busy && is_walk(op);
  assign rd_idx  = walk_q;
  assign done    = busy && (!is_walk(op) || (walk_q == LAST_IDX));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      walk_q <= '0;
    else if (walking)
      walk_q <= (walk_q == LAST_IDX) ? '0 : walk_q + 1'b1;
  end

  logic [MASK_W-1:0] port_bit;
  always_comb begin
    port_bit = '0;
    for (int b = 0; b < MASK_W; b++)
      if (port == PORT_W'(b)) port_bit[b] = 1'b1;
  end

  always_comb begin
    upd_en   = 1'b0;
    upd_idx  = '0;
    upd_ent  = '0;
    set_full = 1'b0;
    if (busy) begin
      case (op)
        OP_LOAD: begin
          upd_ent.valid = 1'b1;
          upd_ent.vid   = vid;
          upd_ent.mask  = dmask;
          if (srch_hit) begin
            upd_en  = 1'b1;
            upd_idx = srch_idx;
          end else if (free_any) begin
            upd_en  = 1'b1;
            upd_idx = free_idx;
          end else begin
            set_full = 1'b1;
          end
        end
        OP_PURGE: begin
          upd_en  = srch_hit;
          upd_idx = srch_idx;
        end
        OP_FLUSH: begin
          upd_en  = 1'b1;
          upd_idx = walk_q;
        end
        OP_RMPORT: begin
          upd_en       = rd_ent.valid;
          upd_idx      = walk_q;
          upd_ent      = rd_ent;
          upd_ent.mask = rd_ent.mask & ~port_bit;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/vtu_cmd_engine.sv
module vtu_cmd_engine
  import vtu_pkg::*;
#(
  parameter int ENTRIES = 16
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_sel,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              lk_valid,
  output logic              lk_ready,
  input  logic [VID_W-1:0]  lk_vid,
  output logic              lk_rsp_valid,
  output logic              lk_hit,
  output logic [MASK_W-1:0] lk_mask
);
  localparam int IDX_W = $clog2(ENTRIES);

  logic [OP_W-1:0]   op_w;
  logic [VID_W-1:0]  vid_w;
  logic [PORT_W-1:0] port_w;
  logic              busy_w, full_w, done_w, set_full_w;
  logic [MASK_W-1:0] dmask_w;
  logic              dvalid_w;
  logic              srch_hit_w, free_any_w, upd_en_w;
  logic [IDX_W-1:0]  srch_idx_w, free_idx_w, rd_idx_w, upd_idx_w;
  vtu_entry_t        rd_ent_w, upd_ent_w;

  assign lk_ready = 1'b1;

  vtu_cmd_regs u_regs (
    .clk, .rst_n, .bus_wr, .bus_sel, .bus_wdata, .bus_rdata,
    .done(done_w), .set_full(set_full_w),
    .op_q(op_w), .vid_q(vid_w), .port_q(port_w), .busy_q(busy_w),
    .full_q(full_w), .dmask_q(dmask_w), .dvalid_q(dvalid_w)
  );

  vtu_engine #(.ENTRIES(ENTRIES)) u_engine (
    .clk, .rst_n, .busy(busy_w), .op(op_w), .vid(vid_w), .port(port_w),
    .dmask(dmask_w), .srch_hit(srch_hit_w), .srch_idx(srch_idx_w),
    .free_any(free_any_w), .free_idx(free_idx_w), .rd_ent(rd_ent_w),
    .rd_idx(rd_idx_w), .upd_en(upd_en_w), .upd_idx(upd_idx_w),
    .upd_ent(upd_ent_w), .done(done_w), .set_full(set_full_w)
  );

  vtu_table #(.ENTRIES(ENTRIES)) u_table (
    .clk, .rst_n, .upd_en(upd_en_w), .upd_idx(upd_idx_w), .upd_ent(upd_ent_w),
    .srch_vid(vid_w), .srch_hit(srch_hit_w), .srch_idx(srch_idx_w),
    .free_any(free_any_w), .free_idx(free_idx_w),
    .rd_idx(rd_idx_w), .rd_ent(rd_ent_w),
    .lk_valid, .lk_vid, .lk_rsp_valid, .lk_hit, .lk_mask
  );

  logic unused_dv;
  assign unused_dv = dvalid_w;
endmodule

// File: rtl/vtu_cmd_engine_chk.sv
module vtu_cmd_engine_chk
  import vtu_pkg::*;
#(
  parameter int ENTRIES = 16
)(
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              full,
  input logic [OP_W-1:0]   op,
  input logic [VID_W-1:0]  vid,
  input logic              bus_wr,
  input logic              bus_sel,
  input logic              lk_valid,
  input logic              lk_rsp_valid,
  input logic              lk_hit,
  input logic [MASK_W-1:0] lk_mask
);
  localparam int CNT_W = $clog2(ENTRIES + 2) + 1;
  logic [CNT_W-1:0] busy_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    busy_cnt <= '0;
    else if (busy) busy_cnt <= busy_cnt + 1'b1;
    else           busy_cnt <= '0;
  end

  AST_SINGLE_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) && !is_walk(op) |=> !busy);                         // R2
  AST_WALK_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) && is_walk(op) |-> busy_cnt == CNT_W'(ENTRIES));    // R7
  AST_FULL_FROM_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(full) |-> $past(busy) && (op == OP_LOAD));                // R5
  AST_BUSY_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    busy && bus_wr && !bus_sel |=> $stable(op) && $stable(vid));    // R9
  AST_LK_RESP: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |=> lk_rsp_valid);                                     // R10
  AST_LK_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |=> !lk_rsp_valid && !lk_hit);                        // R10
  AST_MISS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    lk_rsp_valid && !lk_hit |-> lk_mask == '0);                     // R10
endmodule

bind vtu_cmd_engine vtu_cmd_engine_chk #(.ENTRIES(ENTRIES)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy_w), .full(full_w), .op(op_w),
  .vid(vid_w), .bus_wr(bus_wr), .bus_sel(bus_sel), .lk_valid(lk_valid),
  .lk_rsp_valid(lk_rsp_valid), .lk_hit(lk_hit), .lk_mask(lk_mask)
);

// File: tb/vtu_cmd_engine_tb.sv
module vtu_cmd_engine_tb;
  localparam int N = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic        bus_sel = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        lk_valid = 1'b0;
  logic        lk_ready;
  logic [11:0] lk_vid = '0;
  logic        lk_rsp_valid, lk_hit;
  logic [9:0]  lk_mask;

  int errs = 0;
  int checks = 0;
  bit finished = 1'b0;

  bit         m_valid [N];
  logic [11:0] m_vid  [N];
  logic [9:0]  m_mask [N];
  bit         m_full;
  logic [9:0]  m_dmask;

  always #5 clk = ~clk;

  vtu_cmd_engine #(.ENTRIES(N)) u_dut (
    .clk, .rst_n, .bus_wr, .bus_sel, .bus_wdata, .bus_rdata,
    .lk_valid, .lk_ready, .lk_vid, .lk_rsp_valid, .lk_hit, .lk_mask
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic sel, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_sel = sel; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0; bus_sel = 1'b0;
  endtask

  function automatic logic [31:0] cmd_word(input logic [2:0] op, input logic [11:0] vid,
                                           input logic [3:0] port);
    logic [31:0] w;
    w = '0; w[2:0] = op; w[3] = 1'b1; w[11:8] = port; w[27:16] = vid;
    return w;
  endfunction

  task automatic model_apply(input logic [2:0] op, input logic [11:0] vid, input logic [3:0] port);
    int hit, fr;
    m_full = 1'b0;
    hit = -1; fr = -1;
    for (int i = N - 1; i >= 0; i--) begin
      if (m_valid[i] && m_vid[i] == vid) hit = i;
      if (!m_valid[i]) fr = i;
    end
    case (op)
      3'd1: for (int i = 0; i < N; i++) m_valid[i] = 1'b0;
      3'd2: begin
        if (hit >= 0) m_mask[hit] = m_dmask;
        else if (fr >= 0) begin m_valid[fr] = 1'b1; m_vid[fr] = vid; m_mask[fr] = m_dmask; end
        else m_full = 1'b1;
      end
      3'd3: if (hit >= 0) m_valid[hit] = 1'b0;
      3'd4: if (port < 10) for (int i = 0; i < N; i++) m_mask[i][port] = 1'b0;
      default: ;
    endcase
  endtask

  task automatic write_data(input logic [9:0] m);
    bus_write(1'b1, {20'h0, 1'b1, 1'b0, m});
    m_dmask = m;
  endtask

  task automatic run_cmd(input logic [2:0] op, input logic [11:0] vid, input logic [3:0] port,
                         input string req);
    int n, expn;
    bus_write(1'b0, cmd_word(op, vid, port));
    n = 0;
    while (bus_rdata[3] === 1'b1 && n < 100) begin n++; @(negedge clk); end
    expn = (op == 3'd1 || op == 3'd4) ? 16 : 1;
    check(n == expn, req, n, expn);
    model_apply(op, vid, port);
    check(bus_rdata[4] == m_full, "R5", int'(bus_rdata[4]), int'(m_full));
  endtask

  task automatic lookup_chk(input logic [11:0] vid, input string req);
    bit eh; logic [9:0] em;
    eh = 1'b0; em = '0;
    for (int i = 0; i < N; i++)
      if (m_valid[i] && m_vid[i] == vid) begin eh = 1'b1; em = m_mask[i]; end
    @(negedge clk);
    lk_valid = 1'b1; lk_vid = vid;
    @(negedge clk);
    lk_valid = 1'b0;
    check(lk_rsp_valid == 1'b1, "R10", int'(lk_rsp_valid), 1);
    check(lk_hit == eh && lk_mask == em, req, {lk_hit, lk_mask}, {eh, em});
  endtask

  initial begin
    #(200000 * 10);
    if (!finished) begin
      errs++; checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    logic [11:0] v;
    void'($urandom(32'd20240611));
    for (int i = 0; i < N; i++) begin m_valid[i] = 0; m_vid[i] = '0; m_mask[i] = '0; end
    m_full = 0; m_dmask = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    bus_sel = 1'b0; #1;
    check(bus_rdata == 32'h0, "R1", bus_rdata, 0);
    bus_sel = 1'b1; #1;
    check(bus_rdata == 32'h0, "R1", bus_rdata, 0);
    bus_sel = 1'b0;
    check(lk_rsp_valid == 1'b0, "R10", int'(lk_rsp_valid), 0);
    lookup_chk(12'h000, "R1");

    // R11 data readback
    bus_write(1'b1, 32'hFFFF_FFFF);
    bus_sel = 1'b1; #1;
    check(bus_rdata == 32'h0000_0BFF, "R11", bus_rdata, 32'h0BFF);
    bus_sel = 1'b0;

    // R2/R3 load and R4 overwrite
    write_data(10'h003);
    run_cmd(3'd2, 12'h005, 4'd0, "R2");
    lookup_chk(12'h005, "R3");
    write_data(10'h2A0);
    run_cmd(3'd2, 12'h005, 4'd0, "R4");
    lookup_chk(12'h005, "R4");
    run_cmd(3'd6, 12'h000, 4'd0, "R2");

    // R5 fill the table then overflow
    for (int i = 1; i < N; i++) begin
      write_data(10'(i * 37));
      run_cmd(3'd2, 12'(12'h100 + i), 4'd0, "R3");
    end
    write_data(10'h3FF);
    run_cmd(3'd2, 12'h005, 4'd0, "R4");
    check(bus_rdata[4] == 1'b0, "R4", int'(bus_rdata[4]), 0);
    run_cmd(3'd2, 12'hABC, 4'd0, "R5");
    check(bus_rdata[4] == 1'b1, "R5", int'(bus_rdata[4]), 1);
    lookup_chk(12'hABC, "R5");
    run_cmd(3'd0, 12'h000, 4'd0, "R5");
    check(bus_rdata[4] == 1'b0, "R5", int'(bus_rdata[4]), 0);

    // R6 purge present and absent
    run_cmd(3'd3, 12'h103, 4'd0, "R6");
    lookup_chk(12'h103, "R6");
    run_cmd(3'd3, 12'hEEE, 4'd0, "R6");
    lookup_chk(12'h104, "R6");

    // R8 remove port, in and out of range
    run_cmd(3'd4, 12'h000, 4'd5, "R8");
    lookup_chk(12'h005, "R8");
    lookup_chk(12'h107, "R8");
    run_cmd(3'd4, 12'h000, 4'd12, "R8");
    lookup_chk(12'h10F, "R8");

    // R9 command write during a walk
    bus_write(1'b0, cmd_word(3'd1, 12'h123, 4'd2));
    write_data(10'h155);
    bus_write(1'b0, cmd_word(3'd2, 12'h077, 4'd7));
    while (bus_rdata[3] === 1'b1) @(negedge clk);
    model_apply(3'd1, 12'h123, 4'd2);
    check(bus_rdata[2:0] == 3'd1 && bus_rdata[27:16] == 12'h123 && bus_rdata[11:8] == 4'd2,
          "R9", bus_rdata, 32'h0123_0201);
    lookup_chk(12'h077, "R9");

    // R7 flush after reloading
    write_data(10'h0F0);
    run_cmd(3'd2, 12'h050, 4'd0, "R3");
    run_cmd(3'd1, 12'h000, 4'd0, "R7");
    lookup_chk(12'h050, "R7");

    // random mix
    for (int it = 0; it < 300; it++) begin
      int r;
      r = int'($urandom % 12);
      v = 12'($urandom % 20);
      if (r < 4) begin
        write_data(10'($urandom));
        run_cmd(3'd2, v, 4'd0, "R3");
      end else if (r < 6) run_cmd(3'd3, v, 4'd0, "R6");
      else if (r == 6) run_cmd(3'd4, v, 4'($urandom % 12), "R8");
      else if (r == 7 && ($urandom % 4) == 0) run_cmd(3'd1, v, 4'd0, "R7");
      else if (r == 8) run_cmd(3'(5 + $urandom % 3), v, 4'd0, "R2");
      else if (r == 9) write_data(10'($urandom));
      else begin
        write_data(10'($urandom));
        run_cmd(3'd2, v, 4'd0, "R4");
      end
      lookup_chk(12'($urandom % 20), "R10");
    end

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule